// File: doc/BRIEF.md
# Flash Operation Interrupt Arbiter

This block sits between an embedded flash program/erase sequencer and the processor's interrupt path. It decides what happens to an interrupt request that arrives while the flash is busy. Two kinds of request are handled. An ordinary (maskable) request may pause an erase or wait for it to finish. A critical request (watchdog, oscillator failure, supply monitor) cancels any flash work at once.

A maskable request that arrives while an erase is running can go two ways. If erase pausing is enabled, the block sends a pause pulse to the sequencer. It then waits a fixed latency and acknowledges the request. Software restarts the paused erase later by writing 0 to the resume control. Otherwise, and always during programming, the request stays pending until the sequencer reports idle. A critical request during any unfinished operation works differently. The block sends a one-cycle abort/reset pulse to the flash and sets a sticky flag that marks the erased block or programmed address as unreliable. It acknowledges the critical request only after a fixed recovery period.

Top module: `flash_irq_arbiter`

## Requirements
- R1: With the sequencer idle (`seq_state_i` = 2'b00 or 2'b11) and nothing paused, a maskable request is acknowledged by a one-cycle `mask_ack_o` in the cycle after it is seen.
- R2: A maskable request seen during erase (`seq_state_i` = 2'b10) with `susp_en_i` high produces a one-cycle `suspend_o` in the next cycle. `mask_ack_o` follows exactly `SUSP_LAT` cycles after that pulse, together with `suspended_o` going high.
- R3: While paused, a resume write (`resume_wr_i` high) with `resume_val_i` = 0 gives a one-cycle `resume_o` in the next cycle and clears `suspended_o`. A write with value 1 leaves both unchanged.
- R4: During erase with `susp_en_i` low, a maskable request gets neither a pause nor an acknowledge. It is acknowledged in the cycle after the sequencer reports idle.
- R5: During programming (`seq_state_i` = 2'b01), a maskable request is held until the sequencer reports idle, whatever the value of `susp_en_i`.
- R6: A critical request seen during programming, erase, the pause latency or the paused state gives a one-cycle `abort_o` in the next cycle and clears `suspended_o`. `crit_ack_o` follows exactly `REC_CYC` cycles after `abort_o`.
- R7: A critical request with the sequencer idle and nothing paused is acknowledged in the next cycle, with no abort.
- R8: `aborted_o` goes high with `abort_o`. It stays high until `abort_clr_i` is asserted, and a new abort in the same cycle as a clear wins.
- R9: A resume write while nothing is paused gives no `resume_o` and does not change `suspended_o`.
- R10: A critical request takes precedence over a pending or simultaneous maskable request. No maskable acknowledge is given from the abort until the critical acknowledge.
- R11: `suspend_o`, `abort_o` and `resume_o` are single-cycle pulses, and at most one of them is high in any cycle.
- R12: After reset every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_state_i | input | 2 | Sequencer status: 00 idle, 01 programming, 10 erasing, 11 idle |
| susp_en_i | input | 1 | Erase pausing allowed |
| resume_wr_i | input | 1 | Software write strobe to the resume control |
| resume_val_i | input | 1 | Value written; 0 restarts a paused erase |
| mask_req_i | input | 1 | Maskable interrupt request, held until acknowledged |
| crit_req_i | input | 1 | Critical interrupt request, held until acknowledged |
| abort_clr_i | input | 1 | Clears the sticky abort flag |
| mask_ack_o | output | 1 | Maskable acknowledge pulse |
| crit_ack_o | output | 1 | Critical acknowledge pulse |
| suspend_o | output | 1 | Pause-erase pulse to the sequencer |
| abort_o | output | 1 | Abort/reset pulse to the flash |
| resume_o | output | 1 | Restart-erase pulse to the sequencer |
| suspended_o | output | 1 | An erase is paused |
| aborted_o | output | 1 | Sticky: an operation was aborted |

## Verification
The bench covers every sequencer status with pausing both enabled and disabled. It counts the exact cycle of each pause, acknowledge, abort and recovery acknowledge. An off-by-one latency counter would show up as an acknowledge one cycle early or late. A design that paused during programming, or acknowledged before the erase finished, would pulse `suspend_o` or `mask_ack_o` inside the hold window. Critical requests are driven during the pause latency, while paused, and together with a pending maskable request. A design that let the maskable path win would acknowledge it during recovery or skip the abort. The bench also drives resume writes of 1 and resume writes with nothing paused, and a clear of the flag in the same cycle as an abort.

// File: rtl/flarb_pkg.sv
package flarb_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'b00,
        SEQ_PROG  = 2'b01,
        SEQ_ERASE = 2'b10,
        SEQ_SPARE = 2'b11
    } seq_e;

    typedef enum logic [1:0] {
        ST_RUN,
        ST_SUSP_WAIT,
        ST_PAUSED,
        ST_RECOVER
    } arb_st_e;

    typedef struct packed {
        logic suspend;
        logic abort;
        logic resume;
        logic mask_ack;
        logic crit_ack;
    } arb_cmd_t;

    function automatic logic seq_busy(input logic [1:0] s);
        return (s == SEQ_PROG) || (s == SEQ_ERASE);
    endfunction

    function automatic int cnt_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/flarb_delay.sv
module flarb_delay #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic cancel_i,
    output logic done_o
);
    localparam int CW = flarb_pkg::cnt_w(LEN);

    generate
        if (LEN <= 1) begin : g_single
            logic busy_q;
            always_ff @(posedge clk) begin
                if (rst) busy_q <= 1'b0;
                else     busy_q <= start_i && !cancel_i;
            end
            assign done_o = busy_q;
        end else begin : g_count
            localparam logic [CW-1:0] LAST = CW'(LEN - 1);
            logic          busy_q;
            logic [CW-1:0] cnt_q;
            logic          hit;
            assign hit    = busy_q && (cnt_q == LAST);
            assign done_o = hit;
            always_ff @(posedge clk) begin
                if (rst) begin
                    busy_q <= 1'b0;
                    cnt_q  <= '0;
                end else if (start_i) begin
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                end else if (cancel_i || hit) begin
                    busy_q <= 1'b0;
                end else if (busy_q) begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/flarb_sticky.sv
module flarb_sticky (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    always_ff @(posedge clk) begin
        if (rst)        q_o <= 1'b0;
        else if (set_i) q_o <= 1'b1;
        else if (clr_i) q_o <= 1'b0;
    end
endmodule

// File: rtl/flarb_fsm.sv
module flarb_fsm
    import flarb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] seq_i,
    input  logic       susp_en_i,
    input  logic       resume_wr_i,
    input  logic       resume_val_i,
    input  logic       mask_req_i,
    input  logic       crit_req_i,
    input  logic       lat_done_i,
    input  logic       rec_done_i,
    output logic       lat_start_o,
    output logic       lat_cancel_o,
    output logic       rec_start_o,
    output logic       abort_now_o,
    output arb_cmd_t   cmd_o,
    output logic       paused_o
);
    arb_st_e  st_q, st_d;
    arb_cmd_t cmd_d;

    always_comb begin
        st_d         = st_q;
        cmd_d        = '0;
        lat_start_o  = 1'b0;
        lat_cancel_o = 1'b0;
        rec_start_o  = 1'b0;
        unique case (st_q)
            ST_RUN: begin
                if (crit_req_i) begin
                    if (seq_busy(seq_i)) begin
                        cmd_d.abort = 1'b1;
                        rec_start_o = 1'b1;
                        st_d        = ST_RECOVER;
                    end else begin
                        cmd_d.crit_ack = 1'b1;
                    end
                end else if (mask_req_i) begin
                    if (!seq_busy(seq_i)) begin
                        cmd_d.mask_ack = 1'b1;
                    end else if ((seq_i == SEQ_ERASE) && susp_en_i) begin
                        cmd_d.suspend = 1'b1;
                        lat_start_o   = 1'b1;
                        st_d          = ST_SUSP_WAIT;
                    end
                end
            end
            ST_SUSP_WAIT: begin
                if (crit_req_i) begin
                    cmd_d.abort  = 1'b1;
                    rec_start_o  = 1'b1;
                    lat_cancel_o = 1'b1;
                    st_d         = ST_RECOVER;
                end else if (lat_done_i) begin
                    cmd_d.mask_ack = 1'b1;
                    st_d           = ST_PAUSED;
                end
            end
            ST_PAUSED: begin
                if (crit_req_i) begin
                    cmd_d.abort = 1'b1;
                    rec_start_o = 1'b1;
                    st_d        = ST_RECOVER;
                end else if (resume_wr_i && !resume_val_i) begin
                    cmd_d.resume = 1'b1;
                    st_d         = ST_RUN;
                end else if (mask_req_i) begin
                    cmd_d.mask_ack = 1'b1;
                end
            end
            ST_RECOVER: begin
                if (rec_done_i) begin
                    cmd_d.crit_ack = 1'b1;
                    st_d           = ST_RUN;
                end
            end
            default: st_d = ST_RUN;
        endcase
    end

    assign abort_now_o = cmd_d.abort;
    assign paused_o    = (st_q == ST_PAUSED);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_RUN;
            cmd_o <= '0;
        end else begin
            st_q  <= st_d;
            cmd_o <= cmd_d;
        end
    end
endmodule

// File: rtl/flash_irq_arbiter.sv
module flash_irq_arbiter
    import flarb_pkg::*;
#(
    parameter int SUSP_LAT = 4,
    parameter int REC_CYC  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] seq_state_i,
    input  logic       susp_en_i,
    input  logic       resume_wr_i,
    input  logic       resume_val_i,
    input  logic       mask_req_i,
    input  logic       crit_req_i,
    input  logic       abort_clr_i,
    output logic       mask_ack_o,
    output logic       crit_ack_o,
    output logic       suspend_o,
    output logic       abort_o,
    output logic       resume_o,
    output logic       suspended_o,
    output logic       aborted_o
);
    arb_cmd_t cmd;
    logic lat_start, lat_cancel, lat_done;
    logic rec_start, rec_done, abort_now;

    flarb_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .seq_i        (seq_state_i),
        .susp_en_i    (susp_en_i),
        .resume_wr_i  (resume_wr_i),
        .resume_val_i (resume_val_i),
        .mask_req_i   (mask_req_i),
        .crit_req_i   (crit_req_i),
        .lat_done_i   (lat_done),
        .rec_done_i   (rec_done),
        .lat_start_o  (lat_start),
        .lat_cancel_o (lat_cancel),
        .rec_start_o  (rec_start),
        .abort_now_o  (abort_now),
        .cmd_o        (cmd),
        .paused_o     (suspended_o)
    );

    flarb_delay #(.LEN(SUSP_LAT)) u_lat (
        .clk      (clk),
        .rst      (rst),
        .start_i  (lat_start),
        .cancel_i (lat_cancel),
        .done_o   (lat_done)
    );

    flarb_delay #(.LEN(REC_CYC)) u_rec (
        .clk      (clk),
        .rst      (rst),
        .start_i  (rec_start),
        .cancel_i (1'b0),
        .done_o   (rec_done)
    );

    flarb_sticky u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (abort_now),
        .clr_i (abort_clr_i),
        .q_o   (aborted_o)
    );

    assign mask_ack_o = cmd.mask_ack;
    assign crit_ack_o = cmd.crit_ack;
    assign suspend_o  = cmd.suspend;
    assign abort_o    = cmd.abort;
    assign resume_o   = cmd.resume;
endmodule

// File: rtl/flarb_chk.sv
module flarb_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] seq_state_i,
    input logic       susp_en_i,
    input logic       mask_req_i,
    input logic       abort_clr_i,
    input logic       mask_ack_o,
    input logic       crit_ack_o,
    input logic       suspend_o,
    input logic       abort_o,
    input logic       resume_o,
    input logic       suspended_o,
    input logic       aborted_o
);
    a_r2_suspend_cause: assert property (@(posedge clk) disable iff (rst)
        suspend_o |-> ($past(seq_state_i) == 2'b10) && $past(susp_en_i) && $past(mask_req_i));

    a_r5_busy_holds_mask: assert property (@(posedge clk) disable iff (rst)
        (mask_ack_o && !suspended_o) |-> ($past(seq_state_i) != 2'b01) && ($past(seq_state_i) != 2'b10));

    a_r3_resume_from_pause: assert property (@(posedge clk) disable iff (rst)
        resume_o |-> $past(suspended_o) && !suspended_o);

    a_r8_flag_with_abort: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> aborted_o);

    a_r8_flag_clear_only: assert property (@(posedge clk) disable iff (rst)
        $fell(aborted_o) |-> $past(abort_clr_i));

    a_r10_no_ack_at_abort: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> !mask_ack_o && !crit_ack_o);

    a_r10_recover_blocks_mask: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !mask_ack_o);

    a_r11_suspend_pulse: assert property (@(posedge clk) disable iff (rst)
        suspend_o |=> !suspend_o);

    a_r11_abort_pulse: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o);

    a_r11_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({suspend_o, abort_o, resume_o}));
endmodule

bind flash_irq_arbiter flarb_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .seq_state_i (seq_state_i),
    .susp_en_i   (susp_en_i),
    .mask_req_i  (mask_req_i),
    .abort_clr_i (abort_clr_i),
    .mask_ack_o  (mask_ack_o),
    .crit_ack_o  (crit_ack_o),
    .suspend_o   (suspend_o),
    .abort_o     (abort_o),
    .resume_o    (resume_o),
    .suspended_o (suspended_o),
    .aborted_o   (aborted_o)
);

// File: tb/flash_irq_arbiter_tb.sv
module flash_irq_arbiter_tb_top;
    localparam int CLK_P = 10;
    localparam int LAT   = 3;
    localparam int REC   = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] seq = 2'b00;
    logic susp_en = 1'b0, res_wr = 1'b0, res_val = 1'b1;
    logic mreq = 1'b0, creq = 1'b0, aclr = 1'b0;
    logic mack, cack, susp, abrt, resm, paused, aflag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    flash_irq_arbiter #(.SUSP_LAT(LAT), .REC_CYC(REC)) dut_i (
        .clk(clk), .rst(rst), .seq_state_i(seq), .susp_en_i(susp_en),
        .resume_wr_i(res_wr), .resume_val_i(res_val), .mask_req_i(mreq),
        .crit_req_i(creq), .abort_clr_i(aclr), .mask_ack_o(mack),
        .crit_ack_o(cack), .suspend_o(susp), .abort_o(abrt),
        .resume_o(resm), .suspended_o(paused), .aborted_o(aflag)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    function automatic int outs();
        return {mack, cack, susp, abrt, resm, paused};
    endfunction

    task automatic wait_recovery(input string tag);
        for (int k = 1; k < REC; k++) begin
            cyc();
            chk(!cack && !abrt && !mack, tag, outs(), 0);
        end
        cyc();
        chk(cack == 1'b1, tag, cack, 1);
        creq = 1'b0;
    endtask

    task automatic go_paused();
        seq = 2'b10; susp_en = 1'b1; mreq = 1'b1;
        cyc();
        chk(susp == 1'b1, "R2 pause pulse", susp, 1);
        for (int k = 1; k < LAT; k++) cyc();
        cyc();
        chk(mack && paused, "R2 ack after latency", outs(), 6'b100001);
        mreq = 1'b0; seq = 2'b00;
    endtask

    initial begin
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R12 reset state
        chk(outs() == 0 && !aflag, "R12 reset outputs", outs(), 0);

        // Maskable sweep over sequencer status and pause enable
        for (int s = 0; s < 4; s++) begin
            for (int e = 0; e < 2; e++) begin
                seq = 2'(s); susp_en = e[0]; mreq = 1'b1;
                cyc();
                if (s == 0 || s == 3) begin
                    chk(mack == 1'b1 && !susp, "R1 idle ack", outs(), 6'b100000);
                    mreq = 1'b0;
                    cyc();
                    chk(mack == 1'b0, "R1 ack single", mack, 0);
                end else if (s == 2 && e == 1) begin
                    chk(susp == 1'b1 && !mack, "R2 pause pulse", outs(), 6'b001000);
                    for (int k = 1; k < LAT; k++) begin
                        cyc();
                        chk(!mack && !susp, "R2 latency window", outs(), 0);
                    end
                    cyc();
                    chk(mack && paused, "R2 ack after latency", outs(), 6'b100001);
                    mreq = 1'b0; seq = 2'b00;
                    res_wr = 1'b1; res_val = 1'b1;
                    cyc();
                    res_wr = 1'b0;
                    chk(!resm && paused, "R3 write of 1 ignored", outs(), 6'b000001);
                    res_wr = 1'b1; res_val = 1'b0;
                    cyc();
                    res_wr = 1'b0; res_val = 1'b1;
                    chk(resm == 1'b1, "R3 resume pulse", resm, 1);
                    cyc();
                    chk(!resm && !paused, "R3 resume cleared pause", outs(), 0);
                end else begin
                    for (int k = 0; k < 4; k++) begin
                        chk(!mack && !susp, (s == 1) ? "R5 program holds" : "R4 erase holds", outs(), 0);
                        cyc();
                    end
                    seq = 2'b00;
                    cyc();
                    chk(mack == 1'b1, (s == 1) ? "R5 ack after program" : "R4 ack after erase", mack, 1);
                    mreq = 1'b0;
                    cyc();
                end
            end
        end

        // Critical sweep over sequencer status
        for (int s = 0; s < 4; s++) begin
            seq = 2'(s); creq = 1'b1; aclr = (s == 2);
            cyc();
            aclr = 1'b0;
            if (s == 1 || s == 2) begin
                chk(abrt && !cack, "R6 abort pulse", outs(), 6'b000100);
                chk(aflag == 1'b1, "R8 flag set, set wins over clear", aflag, 1);
                seq = 2'b00;
                wait_recovery("R6 recovery period");
                cyc();
                chk(aflag == 1'b1, "R8 flag sticky", aflag, 1);
                aclr = 1'b1;
                cyc();
                aclr = 1'b0;
                chk(aflag == 1'b0, "R8 flag cleared", aflag, 0);
            end else begin
                chk(cack && !abrt, "R7 idle critical ack", outs(), 6'b010000);
                creq = 1'b0;
                cyc();
                chk(!aflag, "R7 no abort flag", aflag, 0);
            end
        end

        // Critical while paused
        go_paused();
        creq = 1'b1;
        cyc();
        chk(abrt && !paused, "R6 abort from pause", outs(), 6'b000100);
        wait_recovery("R6 recovery from pause");
        aclr = 1'b1; cyc(); aclr = 1'b0;

        // Critical during pause latency with maskable pending
        seq = 2'b10; susp_en = 1'b1; mreq = 1'b1;
        cyc();
        chk(susp == 1'b1, "R2 pause pulse", susp, 1);
        creq = 1'b1;
        cyc();
        chk(abrt && !mack, "R10 critical beats pause latency", outs(), 6'b000100);
        seq = 2'b00;
        wait_recovery("R10 no maskable ack during recovery");
        cyc();
        chk(mack == 1'b1, "R10 maskable served after recovery", mack, 1);
        mreq = 1'b0;
        aclr = 1'b1; cyc(); aclr = 1'b0;

        // Simultaneous critical and maskable during programming
        seq = 2'b01; susp_en = 1'b0; mreq = 1'b1; creq = 1'b1;
        cyc();
        chk(abrt && !mack, "R10 simultaneous critical wins", outs(), 6'b000100);
        seq = 2'b00;
        wait_recovery("R10 recovery blocks maskable");
        mreq = 1'b0;
        aclr = 1'b1; cyc(); aclr = 1'b0;

        // Resume writes with nothing paused
        for (int s = 0; s < 3; s++) begin
            seq = 2'(s); res_wr = 1'b1; res_val = 1'b0;
            cyc();
            res_wr = 1'b0; res_val = 1'b1;
            chk(!resm && !paused && !susp, "R9 resume ignored", outs(), 0);
        end
        seq = 2'b00;
        cyc();
        chk(outs() == 0, "R11 quiet at end", outs(), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule